// File: doc/BRIEF.md
# Length-Programmable Byte Walker

This controller takes a 64-bit word and a 4-bit count, then steps through the requested number of bytes one at a time. The lowest byte comes first, and the bytes follow in ascending order. Each byte passes through three phases, named A, B and C, with one clock cycle per phase. Between one byte and the next, the controller waits for a fixed number of cycles. After the final byte it runs a closing sequence of three phases, named D, E and F. It then raises a one-cycle completion pulse and goes back to idle.

A single byte counter does two jobs. It selects the byte shown on the output, and it tells the controller when to leave the per-byte loop. There is no unrolled chain of states, so the length can change from one job to the next while the logic stays the same. As a placeholder result, the datapath keeps a running sum of the bytes it has processed.

A job is launched by pulsing `start` while the controller is idle. The word and the count are captured on that edge. The caller can then watch the phase strobes and read the byte index, the selected byte and the sum from the outputs.

Top module: `byteseq_top`

## Requirements
- R1: While reset is held, `phaseStrb` is 0, `done` is 0 and `sumOut` is 0.
- R2: When `start` is high on an edge while the controller is idle, `dataIn` and `lenIn` are captured on that edge. The following cycle is phase A with `byteIdx` equal to 0, or phase D if the count is 0.
- R3: `phaseStrb` is one-hot while a phase is active: bit 0 is A, bit 1 is B, bit 2 is C, bit 3 is D, bit 4 is E and bit 5 is F. It is all zero while idle and during wait cycles.
- R4: Each byte k occupies A, B and C on three consecutive cycles. Throughout those cycles, `byteIdx` equals k and `curByte` equals bits 8k+7 down to 8k of the captured word.
- R5: Bytes are visited in ascending order. Between the C of one byte and the A of the next, there are exactly 2 cycles with `phaseStrb` equal to 0.
- R6: The cycle after the C of the last byte is D, and D, E and F then follow on consecutive cycles.
- R7: A count of 0 skips the byte loop, and phase D comes in the cycle right after the start edge.
- R8: A count above 8 is processed as 8 bytes.
- R9: `done` is high for exactly one cycle, the cycle right after F. The controller is idle in that cycle.
- R10: `sumOut` is cleared when a job starts. At the end of each C it adds the current byte. It does not change during D, E and F, and when `done` is high it equals the sum of the processed bytes.
- R11: A `start` pulse while a job is running is ignored. The running job keeps its captured word and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches a job when the controller is idle |
| dataIn | input | 64 | Word holding the bytes to process |
| lenIn | input | 4 | Number of bytes to process (values above 8 act as 8) |
| curByte | output | 8 | Byte chosen by the current index |
| byteIdx | output | 3 | Index of the byte being processed |
| phaseStrb | output | 6 | One-hot phase strobes, A to F on bits 0 to 5 |
| done | output | 1 | One-cycle pulse after the closing phase F |
| sumOut | output | 12 | Running sum of the processed bytes |

## Verification
Timing is counted from the start edge. For a count N of at least 1, byte k enters phase A at cycle 1 + 5k. The sum that includes byte k appears one cycle after that byte's C. D comes at cycle 5N − 1, and `done` comes at cycle 5N + 2. For a count of 0, D comes at cycle 1 and `done` at cycle 4. The bench walks each job one clock at a time and samples on the falling edge. At every cycle it compares the strobe vector, the index, the selected byte and the sum with the value that the schedule above predicts for that cycle. It then confirms that `done` falls again one cycle after its pulse.

// File: rtl/byteseq_pkg.sv
package byteseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_A,
    PH_B,
    PH_C,
    PH_WAIT,
    PH_D,
    PH_E,
    PH_F
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load word, clear sum
    logic accum;    // add current byte to sum
  } dp_ctrl_t;

  localparam int STRB_W = 6;

endpackage

// File: rtl/byteseq_ctrl.sv
module byteseq_ctrl
  import byteseq_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int LEN_W      = 4,
  parameter int GAP_CYCLES = 2,
  localparam int CNT_W     = $clog2(DATA_BYTES + 1),
  localparam int IDX_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
  localparam int GAP_W     = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  lenIn,
  output dp_ctrl_t          dpCtl,
  output logic [IDX_W-1:0]  byteIdx,
  output logic [STRB_W-1:0] phaseStrb,
  output logic              done
);

  phase_e           phase;
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] lenReg;
  logic [GAP_W-1:0] gapCnt;
  logic [CNT_W-1:0] lenClamp;
  logic             lastByte;
  logic             gapEnd;

  // clamp requested length to the number of byte lanes
  always_comb begin
    if (int'(lenIn) > DATA_BYTES) lenClamp = CNT_W'(DATA_BYTES);
    else                          lenClamp = CNT_W'(lenIn);
  end

  assign lastByte = ((byteCnt + CNT_W'(1)) == lenReg);

  generate
    if (GAP_CYCLES > 1) begin : g_gapCount
      assign gapEnd = (gapCnt == GAP_W'(GAP_CYCLES - 1));
    end else begin : g_gapSingle
      assign gapEnd = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      byteCnt <= '0;
      lenReg  <= '0;
      gapCnt  <= '0;
      done    <= 1'b0;
    end else begin
      done <= (phase == PH_F);
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            lenReg  <= lenClamp;
            byteCnt <= '0;
            phase   <= (lenClamp == '0) ? PH_D : PH_A;
          end
        end
        PH_A: phase <= PH_B;
        PH_B: phase <= PH_C;
        PH_C: begin
          if (lastByte) begin
            phase <= PH_D;
          end else begin
            byteCnt <= byteCnt + CNT_W'(1);
            gapCnt  <= '0;
            phase   <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (gapEnd) phase <= PH_A;
          else        gapCnt <= gapCnt + GAP_W'(1);
        end
        PH_D: phase <= PH_E;
        PH_E: phase <= PH_F;
        PH_F: phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtl.capture = (phase == PH_IDLE) && start;
    dpCtl.accum   = (phase == PH_C);
  end

  always_comb begin
    phaseStrb = '0;
    unique case (phase)
      PH_A:    phaseStrb[0] = 1'b1;
      PH_B:    phaseStrb[1] = 1'b1;
      PH_C:    phaseStrb[2] = 1'b1;
      PH_D:    phaseStrb[3] = 1'b1;
      PH_E:    phaseStrb[4] = 1'b1;
      PH_F:    phaseStrb[5] = 1'b1;
      default: phaseStrb    = '0;
    endcase
  end

  assign byteIdx = byteCnt[IDX_W-1:0];

endmodule

// File: rtl/byteseq_dp.sv
module byteseq_dp
  import byteseq_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int IDX_W      = 3,
  parameter int SUM_W      = 12,
  localparam int DATA_W    = DATA_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  dp_ctrl_t          dpCtl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [IDX_W-1:0]  byteIdx,
  output logic [BYTE_W-1:0] curByte,
  output logic [SUM_W-1:0]  sumOut
);

  logic [DATA_W-1:0] dataReg;
  logic [BYTE_W-1:0] lanes [DATA_BYTES];

  genvar g;
  generate
    for (g = 0; g < DATA_BYTES; g++) begin : g_lane
      assign lanes[g] = dataReg[g*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign curByte = lanes[byteIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      dataReg <= '0;
      sumOut  <= '0;
    end else if (dpCtl.capture) begin
      dataReg <= dataIn;
      sumOut  <= '0;
    end else if (dpCtl.accum) begin
      sumOut  <= sumOut + SUM_W'(curByte);
    end
  end

endmodule

// File: rtl/byteseq_top.sv
module byteseq_top
  import byteseq_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int BYTE_W     = 8,
  parameter int LEN_W      = 4,
  parameter int GAP_CYCLES = 2,
  localparam int DATA_W    = DATA_BYTES * BYTE_W,
  localparam int IDX_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
  localparam int SUM_W     = BYTE_W + $clog2(DATA_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [LEN_W-1:0]  lenIn,
  output logic [BYTE_W-1:0] curByte,
  output logic [IDX_W-1:0]  byteIdx,
  output logic [STRB_W-1:0] phaseStrb,
  output logic              done,
  output logic [SUM_W-1:0]  sumOut
);

  dp_ctrl_t dpCtl;

  byteseq_ctrl #(
    .DATA_BYTES(DATA_BYTES),
    .LEN_W     (LEN_W),
    .GAP_CYCLES(GAP_CYCLES)
  ) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .lenIn    (lenIn),
    .dpCtl    (dpCtl),
    .byteIdx  (byteIdx),
    .phaseStrb(phaseStrb),
    .done     (done)
  );

  byteseq_dp #(
    .DATA_BYTES(DATA_BYTES),
    .BYTE_W    (BYTE_W),
    .IDX_W     (IDX_W),
    .SUM_W     (SUM_W)
  ) uDp (
    .clk    (clk),
    .rst    (rst),
    .dpCtl  (dpCtl),
    .dataIn (dataIn),
    .byteIdx(byteIdx),
    .curByte(curByte),
    .sumOut (sumOut)
  );

endmodule

// File: rtl/byteseq_chk.sv
module byteseq_chk #(
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 3,
  parameter int SUM_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] curByte,
  input logic [IDX_W-1:0]  byteIdx,
  input logic [5:0]        phaseStrb,
  input logic              done,
  input logic [SUM_W-1:0]  sumOut
);

  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phaseStrb));

  assert_a_then_b_R4: assert property (@(posedge clk) disable iff (rst)
    phaseStrb[0] |=> phaseStrb[1]);

  assert_b_then_c_R4: assert property (@(posedge clk) disable iff (rst)
    phaseStrb[1] |=> phaseStrb[2]);

  assert_idx_held_R4: assert property (@(posedge clk) disable iff (rst)
    (phaseStrb[0] || phaseStrb[1]) |=> ($stable(byteIdx) && $stable(curByte)));

  assert_gap_after_c_R5: assert property (@(posedge clk) disable iff (rst)
    phaseStrb[2] |=> (phaseStrb == 6'd0 || phaseStrb[3]));

  assert_d_then_e_R6: assert property (@(posedge clk) disable iff (rst)
    phaseStrb[3] |=> phaseStrb[4]);

  assert_e_then_f_R6: assert property (@(posedge clk) disable iff (rst)
    phaseStrb[4] |=> phaseStrb[5]);

  assert_done_after_f_R9: assert property (@(posedge clk) disable iff (rst)
    phaseStrb[5] |=> (done && phaseStrb == 6'd0));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_sum_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (phaseStrb[3] || phaseStrb[4]) |=> $stable(sumOut));

endmodule

bind byteseq_top byteseq_chk #(
  .BYTE_W(BYTE_W),
  .IDX_W (IDX_W),
  .SUM_W (SUM_W)
) uChk (
  .clk      (clk),
  .rst      (rst),
  .curByte  (curByte),
  .byteIdx  (byteIdx),
  .phaseStrb(phaseStrb),
  .done     (done),
  .sumOut   (sumOut)
);

// File: tb/byteseq_top_test.sv
module byteseq_top_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] dataIn = '0;
  logic [3:0]  lenIn = '0;
  logic [7:0]  curByte;
  logic [2:0]  byteIdx;
  logic [5:0]  phaseStrb;
  logic        done;
  logic [11:0] sumOut;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byteseq_top uut (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dataIn   (dataIn),
    .lenIn    (lenIn),
    .curByte  (curByte),
    .byteIdx  (byteIdx),
    .phaseStrb(phaseStrb),
    .done     (done),
    .sumOut   (sumOut)
  );

  function automatic int effLen(input logic [3:0] l);
    return (int'(l) > 8) ? 8 : int'(l);
  endfunction

  function automatic logic [7:0] laneOf(input logic [63:0] d, input int k);
    return d[8*k +: 8];
  endfunction

  function automatic logic [11:0] sumUpTo(input logic [63:0] d, input int n);
    logic [11:0] s = '0;
    for (int k = 0; k < n; k++) s += 12'(laneOf(d, k));
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one job; samples every cycle on the falling edge
  task automatic runJob(input logic [63:0] d, input logic [3:0] l, input bit poke);
    int n = effLen(l);
    logic [11:0] partial = '0;
    start = 1'b1; dataIn = d; lenIn = l;
    step();
    start = 1'b0; dataIn = ~d; lenIn = ~l;
    for (int k = 0; k < n; k++) begin
      chk(phaseStrb == 6'b000001, (k == 0) ? "R2 first A" : "R5 next A", phaseStrb, 6'b000001);
      chk(byteIdx == 3'(k), "R4 idx in A", byteIdx, k);
      chk(curByte == laneOf(d, k), "R4 byte in A", curByte, laneOf(d, k));
      if (poke && k == 0) begin
        start = 1'b1; dataIn = 64'hFFFF_FFFF_FFFF_FFFF; lenIn = 4'd0;
        step();
        start = 1'b0;
      end else begin
        step();
      end
      chk(phaseStrb == 6'b000010, "R4 B", phaseStrb, 6'b000010);
      chk(curByte == laneOf(d, k), poke ? "R11 byte kept" : "R4 byte in B", curByte, laneOf(d, k));
      step();
      chk(phaseStrb == 6'b000100, "R4 C", phaseStrb, 6'b000100);
      chk(byteIdx == 3'(k), "R4 idx in C", byteIdx, k);
      step();
      partial = partial + 12'(laneOf(d, k));
      if (k < n - 1) begin
        chk(phaseStrb == 6'd0, "R5 gap 1", phaseStrb, 0);
        chk(sumOut == partial, "R10 partial sum", sumOut, partial);
        step();
        chk(phaseStrb == 6'd0, "R5 gap 2", phaseStrb, 0);
        step();
      end
    end
    chk(phaseStrb == 6'b001000, (n == 0) ? "R7 direct D" : "R6 D after last C", phaseStrb, 6'b001000);
    chk(sumOut == partial, "R10 sum at D", sumOut, partial);
    step();
    chk(phaseStrb == 6'b010000, "R6 E", phaseStrb, 6'b010000);
    step();
    chk(phaseStrb == 6'b100000, "R6 F", phaseStrb, 6'b100000);
    chk(done == 1'b0, "R9 no early done", done, 0);
    step();
    chk(done == 1'b1, "R9 done pulse", done, 1);
    chk(phaseStrb == 6'd0, "R9 idle at done", phaseStrb, 0);
    chk(sumOut == sumUpTo(d, n), (int'(l) > 8) ? "R8 clamped sum" : "R10 final sum", sumOut, sumUpTo(d, n));
    step();
    chk(done == 1'b0, "R9 done falls", done, 0);
    chk(phaseStrb == 6'd0, "R9 stays idle", phaseStrb, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seedVal;
    seedVal = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phaseStrb == 6'd0, "R1 strobes in reset", phaseStrb, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(sumOut == 12'd0, "R1 sum in reset", sumOut, 0);
    rst = 1'b0;
    step();

    runJob(64'h8877_6655_4433_2211, 4'd1, 1'b0);
    runJob(64'hF0E1_D2C3_B4A5_9687, 4'd8, 1'b0);
    runJob(64'h0123_4567_89AB_CDEF, 4'd0, 1'b0);   // R7
    runJob(64'hFFFF_FFFF_FFFF_FFFF, 4'd15, 1'b0);  // R8
    runJob(64'h1020_3040_5060_7080, 4'd9, 1'b0);   // R8
    runJob(64'hDEAD_BEEF_CAFE_F00D, 4'd3, 1'b1);   // R11
    runJob(64'h0000_0000_0000_00AA, 4'd0, 1'b1);

    for (int j = 0; j < 40; j++) begin
      logic [63:0] d = {$urandom, $urandom};
      logic [3:0]  l = 4'($urandom % 16);
      bit          p = ($urandom % 4) == 0;
      if (p && l == 4'd0) p = 1'b0;
      runJob(d, l, p);
      repeat ($urandom % 3) step();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule